// File: doc/BRIEF.md
# Test Bus Master

This block lets an external tester take over a system bus through a fixed 32-bit test port. Two request pins form a two-bit command that steps a small state machine. Before the block does anything on the bus, it requests the bus and waits for a grant. Once it holds the bus, one command copies the test port value into an address register, which then drives the system address bus. Two other commands open a write or a read transfer.

The block never drives system data from its own logic. During a transfer it switches the external bus interface into pass-through mode. That interface then forms a bidirectional 32-bit path between the test port and the system data bus, and it stops answering as a normal slave. The direction of the path is set one cycle before any data driver turns on. An acknowledge pulse marks each completed latch and each completed transfer.

Top module: `test_bus_master`

## Requirements
- R1: While `rst_ni` is low, these outputs are 0: `bus_req_o`, `sys_addr_oe_o`, `ovr_en_o`, `sys_xfer_o`, `sys_doe_o`, `tbus_oe_o` and `ack_o`. `sys_addr_o` resets to 0.
- R2: The command is `{treq_a_i,treq_b_i}`. From idle, a nonzero command raises `bus_req_o` in the next cycle. `sys_addr_oe_o` rises only in the cycle after `bus_gnt_i` is sampled high while the request is pending.
- R3: In the ready state, command 2'b10 loads `tbus_d_i` into `sys_addr_o` for the next cycle, and `ack_o` is high for that one cycle. If 2'b10 stays applied, no further load or acknowledge happens. A new load needs the command to leave 2'b10 first.
- R4: In the ready state, command 2'b01 enters a write. In the next cycle `ovr_en_o`=1, `ovr_dir_o`=0 and no data driver is on. From the cycle after that, `sys_doe_o`=1, `sys_d_o` follows `tbus_d_i` combinationally, and `sys_xfer_o`=`sys_wr_o`=1.
- R5: In the ready state, command 2'b11 enters a read. In the next cycle `ovr_en_o`=1, `ovr_dir_o`=1 and no driver is on. From the cycle after that, `tbus_oe_o`=1, `tbus_d_o` follows `sys_d_i`, `sys_xfer_o`=1 and `sys_wr_o`=0.
- R6: Command 2'b00 during a transfer completes it. In the next cycle `ovr_en_o` and both data enables are 0, `ack_o` pulses once, `bus_req_o` and `sys_addr_oe_o` stay 1, and `sys_addr_o` is unchanged.
- R7: During a transfer, any nonzero command has no effect. The direction and the active driver stay as they are.
- R8: `ebi_slave_sel_o` equals `ebi_sel_i` while `ovr_en_o` is 0, and is 0 while `ovr_en_o` is 1.
- R9: If `bus_gnt_i` is low in any granted state, the block returns to idle in the next cycle. `bus_req_o`, `sys_addr_oe_o` and `ovr_en_o` go to 0, and the block gives no acknowledge and performs no address load, even if a completion or a load command is present in the same cycle.
- R10: `tbus_oe_o` and `sys_doe_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| treq_a_i | input | 1 | Command bit 1 |
| treq_b_i | input | 1 | Command bit 0 |
| tbus_d_i | input | 32 | Test port data in |
| tbus_d_o | output | 32 | Test port data out (read path) |
| tbus_oe_o | output | 1 | Test port output enable |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| sys_addr_o | output | ADDR_W | Latched system address |
| sys_addr_oe_o | output | 1 | Address bus drive enable |
| sys_xfer_o | output | 1 | Data phase active |
| sys_wr_o | output | 1 | Data phase is a write |
| sys_d_i | input | 32 | System data bus in |
| sys_d_o | output | 32 | System data bus out (write path) |
| sys_doe_o | output | 1 | System data bus drive enable |
| ovr_en_o | output | 1 | Pass-through override to external bus interface |
| ovr_dir_o | output | 1 | Override direction, 1 = read |
| ebi_sel_i | input | 1 | Normal slave select for external bus interface |
| ebi_slave_sel_o | output | 1 | Gated slave select |
| ack_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a loss of grant together with a transfer completion. The second is a loss of grant together with an address load command. The bench provokes the first by holding a write in its data phase, then applying command 2'b00 and dropping `bus_gnt_i` on the same edge. It provokes the second by applying 2'b10 with a new test port value in the ready state on the edge where the grant falls. In both cases the bench expects the bus to be released with no acknowledge. The scoreboard fails any acknowledge it did not expect, and the bench checks that `sys_addr_o` still holds the earlier address.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int TBUS_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RDY,
    ST_WR,
    ST_RD
  } tbm_state_e;

  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] CMD_WR   = 2'b01;
  localparam logic [1:0] CMD_ADDR = 2'b10;
  localparam logic [1:0] CMD_RD   = 2'b11;
endpackage

// File: rtl/tbm_fsm.sv
module tbm_fsm
  import tbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       gnt_i,
  output logic       bus_req_o,
  output logic       addr_oe_o,
  output logic       load_o,
  output logic       ovr_en_o,
  output logic       dir_o,
  output logic       active_o,
  output logic       ack_o
);
  tbm_state_e state_q, state_d;
  logic dir_q, dir_d, active_q, active_d, ack_q, ack_d, armed_q, armed_d, load;

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    active_d = 1'b0;
    ack_d    = 1'b0;
    armed_d  = armed_q;
    load     = 1'b0;
    if (cmd_i != CMD_ADDR) armed_d = 1'b1;
    unique case (state_q)
      ST_IDLE: if (cmd_i != CMD_NOP) state_d = ST_REQ;
      ST_REQ:  if (gnt_i) state_d = ST_RDY;
      ST_RDY: begin
        if (!gnt_i) state_d = ST_IDLE;
        else begin
          unique case (cmd_i)
            CMD_ADDR: if (armed_q) begin
              load    = 1'b1;
              ack_d   = 1'b1;
              armed_d = 1'b0;
            end
            CMD_WR: begin
              state_d = ST_WR;
              dir_d   = 1'b0;
            end
            CMD_RD: begin
              state_d = ST_RD;
              dir_d   = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_WR, ST_RD: begin
        if (!gnt_i) state_d = ST_IDLE;
        else if (cmd_i == CMD_NOP) begin
          state_d = ST_RDY;
          ack_d   = 1'b1;
        end else active_d = 1'b1;  // other codes ignored mid-transfer
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
      ack_q    <= 1'b0;
      armed_q  <= 1'b1;
    end else begin
      state_q  <= state_d;
      dir_q    <= dir_d;
      active_q <= active_d;
      ack_q    <= ack_d;
      armed_q  <= armed_d;
    end
  end

  assign bus_req_o = (state_q != ST_IDLE);
  assign addr_oe_o = (state_q == ST_RDY) || (state_q == ST_WR) || (state_q == ST_RD);
  assign ovr_en_o  = (state_q == ST_WR) || (state_q == ST_RD);
  assign dir_o     = dir_q;
  assign active_o  = active_q;
  assign ack_o     = ack_q;
  assign load_o    = load;

  AST_GNT_BEFORE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> $past(gnt_i)) else $error("addr drive without grant");  // R2
  AST_GNT_LOSS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_oe_o && !gnt_i) |=> (!addr_oe_o && !ovr_en_o && !ack_o)) else $error("grant loss not honoured");  // R9
  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_en_o && $past(ovr_en_o)) |-> $stable(dir_o)) else $error("direction moved mid-transfer");  // R7
endmodule

// File: rtl/tbm_addr_latch.sv
module tbm_addr_latch
  import tbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TBUS_W-1:0] tbus_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (load_i) addr_q <= tbus_i[ADDR_W-1:0];
  end

  assign addr_o = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o)) else $error("address changed without load");  // R3
endmodule

// File: rtl/tbm_pass_channel.sv
module tbm_pass_channel
  import tbm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovr_en_i,
  input  logic              dir_i,
  input  logic              active_i,
  input  logic [TBUS_W-1:0] tbus_d_i,
  input  logic [TBUS_W-1:0] sys_d_i,
  input  logic              ebi_sel_i,
  output logic [TBUS_W-1:0] tbus_d_o,
  output logic              tbus_oe_o,
  output logic [TBUS_W-1:0] sys_d_o,
  output logic              sys_doe_o,
  output logic              ebi_slave_sel_o
);
  logic drive_rd, drive_wr;

  // drivers only after the registered direction has settled for a cycle
  assign drive_rd        = ovr_en_i && active_i && dir_i;
  assign drive_wr        = ovr_en_i && active_i && !dir_i;
  assign tbus_oe_o       = drive_rd;
  assign tbus_d_o        = drive_rd ? sys_d_i : '0;
  assign sys_doe_o       = drive_wr;
  assign sys_d_o         = drive_wr ? tbus_d_i : '0;
  assign ebi_slave_sel_o = ebi_sel_i && !ovr_en_i;

  AST_SINGLE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tbus_oe_o && sys_doe_o)) else $error("both directions driven");  // R10
  AST_WR_DIR_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_doe_o |-> $past(ovr_en_i && !dir_i)) else $error("write drive before direction");  // R4
  AST_RD_DIR_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbus_oe_o |-> $past(ovr_en_i && dir_i)) else $error("read drive before direction");  // R5
endmodule

// File: rtl/test_bus_master.sv
module test_bus_master
  import tbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              treq_a_i,
  input  logic              treq_b_i,
  input  logic [TBUS_W-1:0] tbus_d_i,
  output logic [TBUS_W-1:0] tbus_d_o,
  output logic              tbus_oe_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic              sys_addr_oe_o,
  output logic              sys_xfer_o,
  output logic              sys_wr_o,
  input  logic [TBUS_W-1:0] sys_d_i,
  output logic [TBUS_W-1:0] sys_d_o,
  output logic              sys_doe_o,
  output logic              ovr_en_o,
  output logic              ovr_dir_o,
  input  logic              ebi_sel_i,
  output logic              ebi_slave_sel_o,
  output logic              ack_o
);
  logic load, ovr_en, dir, active;

  tbm_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     ({treq_a_i, treq_b_i}),
    .gnt_i     (bus_gnt_i),
    .bus_req_o (bus_req_o),
    .addr_oe_o (sys_addr_oe_o),
    .load_o    (load),
    .ovr_en_o  (ovr_en),
    .dir_o     (dir),
    .active_o  (active),
    .ack_o     (ack_o)
  );

  tbm_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .tbus_i (tbus_d_i),
    .addr_o (sys_addr_o)
  );

  tbm_pass_channel u_chan (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ovr_en_i        (ovr_en),
    .dir_i           (dir),
    .active_i        (active),
    .tbus_d_i        (tbus_d_i),
    .sys_d_i         (sys_d_i),
    .ebi_sel_i       (ebi_sel_i),
    .tbus_d_o        (tbus_d_o),
    .tbus_oe_o       (tbus_oe_o),
    .sys_d_o         (sys_d_o),
    .sys_doe_o       (sys_doe_o),
    .ebi_slave_sel_o (ebi_slave_sel_o)
  );

  assign ovr_en_o   = ovr_en;
  assign ovr_dir_o  = dir;
  assign sys_xfer_o = active;
  assign sys_wr_o   = active && !dir;
endmodule

// File: tb/test_bus_master_bench.sv
`timescale 1ns/1ps
module test_bus_master_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        treq_a = 1'b0, treq_b = 1'b0, gnt = 1'b0, ebi_sel = 1'b0;
  logic [31:0] tbus_d = '0, sys_d = '0;
  logic [31:0] tbus_q, sys_q, addr;
  logic        tbus_oe, bus_req, addr_oe, xfer, wr, doe, ovr, dir, slv, ack;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  test_bus_master u_test_bus_master (
    .clk_i(clk), .rst_ni(rst_ni), .treq_a_i(treq_a), .treq_b_i(treq_b),
    .tbus_d_i(tbus_d), .tbus_d_o(tbus_q), .tbus_oe_o(tbus_oe),
    .bus_req_o(bus_req), .bus_gnt_i(gnt), .sys_addr_o(addr),
    .sys_addr_oe_o(addr_oe), .sys_xfer_o(xfer), .sys_wr_o(wr),
    .sys_d_i(sys_d), .sys_d_o(sys_q), .sys_doe_o(doe), .ovr_en_o(ovr),
    .ovr_dir_o(dir), .ebi_sel_i(ebi_sel), .ebi_slave_sel_o(slv), .ack_o(ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] c);
    {treq_a, treq_b} = c;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor: every acknowledge must match a queued expected address
  initial forever begin
    @(posedge clk);
    #2;
    if (rst_ni && ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R6/R9 unexpected ack act=%h exp=none", addr);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (addr !== e) begin
          fails++;
          $display("FAIL R3/R6 ack addr act=%h exp=%h", addr, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    // R1
    chk("R1 bus_req", bus_req, 0); chk("R1 addr_oe", addr_oe, 0);
    chk("R1 ovr", ovr, 0); chk("R1 doe", doe, 0); chk("R1 tbus_oe", tbus_oe, 0);
    chk("R1 xfer", xfer, 0); chk("R1 ack", ack, 0); chk("R1 addr", addr, 0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();

    // R2 request and grant
    cmd(2'b10); tbus_d = 32'hA1A1_0001;
    tick();
    chk("R2 bus_req", bus_req, 1); chk("R2 addr_oe no gnt", addr_oe, 0);
    tick();
    chk("R2 addr_oe wait", addr_oe, 0);
    gnt = 1'b1;
    tick();
    chk("R2 addr_oe after gnt", addr_oe, 1);

    // R3 latch
    exp_q.push_back(32'hA1A1_0001);
    tick();
    chk("R3 addr load", addr, 32'hA1A1_0001);
    tbus_d = 32'hB2B2_0002;
    tick();
    chk("R3 held no reload", addr, 32'hA1A1_0001); chk("R3 held no ack", ack, 0);
    cmd(2'b00);
    tick();
    cmd(2'b10); tbus_d = 32'hC3C3_0003; exp_q.push_back(32'hC3C3_0003);
    tick();
    chk("R3 rearmed load", addr, 32'hC3C3_0003);

    // R4 write
    cmd(2'b01); tbus_d = 32'hD4D4_0004; ebi_sel = 1'b1;
    tick();
    chk("R4 ovr", ovr, 1); chk("R4 dir", dir, 0); chk("R4 doe setup", doe, 0);
    chk("R4 xfer setup", xfer, 0); chk("R8 slave blocked", slv, 0);
    tick();
    chk("R4 doe", doe, 1); chk("R4 data", sys_q, 32'hD4D4_0004);
    chk("R4 wr", wr, 1); chk("R4 xfer", xfer, 1); chk("R10 tbus_oe off", tbus_oe, 0);
    tbus_d = 32'hE5E5_0005;
    #1;
    chk("R4 data follows", sys_q, 32'hE5E5_0005);
    cmd(2'b11);
    tick();
    chk("R7 dir kept", dir, 0); chk("R7 doe kept", doe, 1);
    cmd(2'b00); exp_q.push_back(32'hC3C3_0003);
    tick();
    chk("R6 ovr off", ovr, 0); chk("R6 doe off", doe, 0);
    chk("R6 bus kept", bus_req, 1); chk("R6 addr_oe kept", addr_oe, 1);
    chk("R6 addr kept", addr, 32'hC3C3_0003); chk("R8 slave restored", slv, 1);

    // R5 read
    cmd(2'b11); sys_d = 32'hF6F6_0006;
    tick();
    chk("R5 dir", dir, 1); chk("R5 tbus_oe setup", tbus_oe, 0); chk("R5 ovr", ovr, 1);
    tick();
    chk("R5 tbus_oe", tbus_oe, 1); chk("R5 data", tbus_q, 32'hF6F6_0006);
    chk("R5 wr", wr, 0); chk("R5 xfer", xfer, 1); chk("R10 doe off", doe, 0);
    cmd(2'b01);
    tick();
    chk("R7 dir kept rd", dir, 1); chk("R7 tbus_oe kept", tbus_oe, 1);
    cmd(2'b00); exp_q.push_back(32'hC3C3_0003);
    tick();
    chk("R6 rd ovr off", ovr, 0); chk("R6 rd tbus_oe off", tbus_oe, 0);

    // R9 grant loss with completion
    cmd(2'b01);
    tick(); tick();
    chk("R9 pre doe", doe, 1);
    cmd(2'b00); gnt = 1'b0;
    tick();
    chk("R9 bus_req", bus_req, 0); chk("R9 addr_oe", addr_oe, 0);
    chk("R9 ovr", ovr, 0); chk("R9 doe", doe, 0);
    tick();
    chk("R9 stays idle", bus_req, 0);

    // R9 grant loss with load
    cmd(2'b01); gnt = 1'b1;
    tick(); tick();
    chk("R9 ready again", addr_oe, 1);
    cmd(2'b10); tbus_d = 32'h7777_7777; gnt = 1'b0;
    tick();
    chk("R9 no load", addr, 32'hC3C3_0003); chk("R9 addr_oe drop", addr_oe, 0);
    cmd(2'b00);
    tick(); tick();
    chk("R3/R6 all acks seen", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule